// File: doc/BRIEF.md
# Flip-Index Test Slice Decompressor

This block rebuilds scan test slices on chip from a serial stream of bit positions rather than bit values. Each clock shifts one stream bit into a short index register. The shifted value, read as a plain binary number, names one bit of a held slice. When the flip enable is high, that bit is inverted. A new index reuses the older index bits that are still in the register, so a run of nearby positions costs one clock each instead of a full index width. Once a slice is complete, the tester raises an apply strobe, and the finished slice goes out to the parallel scan chain inputs with a one-cycle valid pulse.

The working slice sits in its own register. It survives while the scan cells are overwritten by captured responses, and it serves as the base for the next mutation. The flip enable can come from a dedicated input. It can also come from a pad that is shared with the serial response output: a mode input turns that pad around. The slice width equals the number of scan chains. It is a parameter, a power of two from 4 to 32, and the index register is log2 of that width wide.

Top module: `slice_mutator`

## Requirements
- R1: A synchronous active-high reset clears the index register, the working slice and the chain data to zero and holds the chain valid output low.
- R2: On every clock the serial input bit enters the most-significant end of the index register and the other bits move one place toward the least-significant end, so after bits b0, b1, b2 (in that order) an 8-bit slice uses index {b2,b1,b0}.
- R3: When the effective flip enable is high on a clock, exactly one working-slice bit is inverted: bit k, where k is the index formed on that same clock with the new serial bit already included (index 0 selects slice bit 0, index SLICE_W-1 selects the top bit).
- R4: When the effective flip enable is low, the working slice keeps its value while the index register still shifts.
- R5: Consecutive overlapping indices cost one clock each: with index 5 (binary 101) held, serial bits 1 then 1 under enable flip bits 6 and then 7 on the next two clocks.
- R6: An apply strobe on a clock makes the chain valid output high on the next cycle, with the chain data equal to the working slice as it stood before that clock; a flip made on the same clock lands only in the working slice, and the working slice is not cleared by apply.
- R7: Chain valid is high only in the cycle after an apply strobe, and the chain data holds its value in every other cycle.
- R8: With the share mode input low, the flip enable comes from the dedicated enable input, the pad drives out (pad output enable = 1) and the pad output follows the response input. With share mode high, the flip enable comes from the pad input, the pad output enable is 0 and the pad output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| share_mode | input | 1 | 1: flip enable taken from the shared pad |
| ser_idx | input | 1 | Serial index stream, one bit per clock |
| flip_req | input | 1 | Dedicated flip enable (share_mode = 0) |
| pad_in | input | 1 | Shared pad input value, flip enable when share_mode = 1 |
| resp_bit | input | 1 | Serial response bit to be driven out on the pad |
| apply | input | 1 | Slice complete strobe |
| pad_out | output | 1 | Shared pad output value |
| pad_oe | output | 1 | Shared pad output enable |
| work_slice | output | SLICE_W | Working (mutated) slice register |
| chain_data | output | SLICE_W | Slice presented to the scan chain inputs |
| chain_valid | output | 1 | One-cycle pulse marking chain_data as a new slice |

## Verification
On every cycle the assertions check that the reset state is clean. They check that any enabled clock changes the working slice in exactly the position held in the index register, and that a disabled clock changes nothing. They also check the apply-to-valid pulse and its captured data, and the pad direction in both modes. What only the bench scenarios can show is that a given serial bit order produces the intended index. Overlapping indices flip a chain of neighbouring bits at one clock each, and a bit flipped twice returns to its old value. A flip on the apply clock is kept out of the emitted slice, and switching the enable source really changes which pin controls flipping.

// File: rtl/slice_mut_pkg.sv
package slice_mut_pkg;

    typedef enum logic {
        EN_SRC_DEDICATED = 1'b0,
        EN_SRC_PAD       = 1'b1
    } en_src_e;

    typedef struct packed {
        logic flip;
        logic apply;
    } step_ctrl_t;

    function automatic bit width_ok(input int w);
        return (w == 4) || (w == 8) || (w == 16) || (w == 32);
    endfunction

endpackage

// File: rtl/idx_shifter.sv
module idx_shifter #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bit_in,
    output logic [IDX_W-1:0] idx_now,
    output logic [IDX_W-1:0] idx_q
);
    generate
        if (IDX_W == 1) begin : g_one
            assign idx_now = bit_in;
        end else begin : g_many
            assign idx_now = {bit_in, idx_q[IDX_W-1:1]};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) idx_q <= '0;
        else     idx_q <= idx_now;
    end
endmodule

// File: rtl/onehot_dec.sv
module onehot_dec #(
    parameter int IDX_W = 3,
    parameter int OUT_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    output logic [OUT_W-1:0] onehot
);
    for (genvar g = 0; g < OUT_W; g++) begin : g_line
        assign onehot[g] = (idx == IDX_W'(g));
    end
endmodule

// File: rtl/slice_store.sv
module slice_store
    import slice_mut_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  step_ctrl_t   ctrl,
    input  logic [W-1:0] sel,
    output logic [W-1:0] slice_q,
    output logic [W-1:0] out_data,
    output logic         out_valid
);
    logic [W-1:0] slice_d;

    always_comb begin
        slice_d = slice_q;
        if (ctrl.flip) slice_d = slice_q ^ sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            slice_q   <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
        end else begin
            slice_q   <= slice_d;
            out_valid <= ctrl.apply;
            if (ctrl.apply) out_data <= slice_q;
        end
    end
endmodule

// File: rtl/pin_share.sv
module pin_share
    import slice_mut_pkg::*;
(
    input  en_src_e src,
    input  logic    flip_req,
    input  logic    pad_in,
    input  logic    resp_bit,
    output logic    en_eff,
    output logic    pad_out,
    output logic    pad_oe
);
    always_comb begin
        unique case (src)
            EN_SRC_PAD: begin
                en_eff  = pad_in;
                pad_out = 1'b0;
                pad_oe  = 1'b0;
            end
            default: begin
                en_eff  = flip_req;
                pad_out = resp_bit;
                pad_oe  = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/slice_mutator.sv
module slice_mutator
    import slice_mut_pkg::*;
#(
    parameter int SLICE_W = 8,
    localparam int IDX_W  = $clog2(SLICE_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               share_mode,
    input  logic               ser_idx,
    input  logic               flip_req,
    input  logic               pad_in,
    input  logic               resp_bit,
    input  logic               apply,
    output logic               pad_out,
    output logic               pad_oe,
    output logic [SLICE_W-1:0] work_slice,
    output logic [SLICE_W-1:0] chain_data,
    output logic               chain_valid
);
    generate
        if (!width_ok(SLICE_W)) begin : g_bad_width
            $error("slice_mutator: SLICE_W must be 4, 8, 16 or 32");
        end
    endgenerate

    logic [IDX_W-1:0]   idx_now;
    logic [IDX_W-1:0]   idx_q;
    logic [SLICE_W-1:0] sel_line;
    logic               en_eff;
    en_src_e            src;
    step_ctrl_t         ctrl;

    assign src        = share_mode ? EN_SRC_PAD : EN_SRC_DEDICATED;
    assign ctrl.flip  = en_eff;
    assign ctrl.apply = apply;

    pin_share u_pin (
        .src      (src),
        .flip_req (flip_req),
        .pad_in   (pad_in),
        .resp_bit (resp_bit),
        .en_eff   (en_eff),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe)
    );

    idx_shifter #(.IDX_W(IDX_W)) u_idx (
        .clk     (clk),
        .rst     (rst),
        .bit_in  (ser_idx),
        .idx_now (idx_now),
        .idx_q   (idx_q)
    );

    onehot_dec #(.IDX_W(IDX_W), .OUT_W(SLICE_W)) u_dec (
        .idx    (idx_now),
        .onehot (sel_line)
    );

    slice_store #(.W(SLICE_W)) u_store (
        .clk       (clk),
        .rst       (rst),
        .ctrl      (ctrl),
        .sel       (sel_line),
        .slice_q   (work_slice),
        .out_data  (chain_data),
        .out_valid (chain_valid)
    );
endmodule

// File: rtl/slice_mutator_chk.sv
module slice_mutator_chk #(
    parameter int SLICE_W = 8,
    parameter int IDX_W   = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               share_mode,
    input logic               resp_bit,
    input logic               apply,
    input logic               en_eff,
    input logic               pad_out,
    input logic               pad_oe,
    input logic [IDX_W-1:0]   idx_q,
    input logic [SLICE_W-1:0] work_slice,
    input logic [SLICE_W-1:0] chain_data,
    input logic               chain_valid
);
    logic rst_d;
    logic live_q;

    always_ff @(posedge clk) begin
        rst_d  <= rst;
        live_q <= rst ? 1'b0 : 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst_d |-> (work_slice == '0 && chain_data == '0 && !chain_valid && idx_q == '0));

    // R2 and R3: the slice changes in exactly the position now in the index register
    assert_flip_at_index_R3: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(rst) && $past(en_eff))
        |-> ((work_slice ^ $past(work_slice)) == (SLICE_W'(1) << idx_q)));

    assert_single_bit_R3: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(rst) && $past(en_eff))
        |-> ($countones(work_slice ^ $past(work_slice)) == 1));

    assert_hold_no_enable_R4: assert property (@(posedge clk) disable iff (rst)
        (live_q && !$past(rst) && !$past(en_eff)) |-> $stable(work_slice));

    assert_apply_emits_R6: assert property (@(posedge clk) disable iff (rst)
        (live_q && apply) |=> (chain_valid && chain_data == $past(work_slice)));

    assert_no_spurious_valid_R7: assert property (@(posedge clk) disable iff (rst)
        (live_q && !apply) |=> (!chain_valid && $stable(chain_data)));

    assert_pad_shared_R8: assert property (@(posedge clk) disable iff (rst)
        share_mode |-> (!pad_oe && !pad_out));

    assert_pad_dedicated_R8: assert property (@(posedge clk) disable iff (rst)
        !share_mode |-> (pad_oe && pad_out == resp_bit));
endmodule

bind slice_mutator slice_mutator_chk #(.SLICE_W(SLICE_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .share_mode  (share_mode),
    .resp_bit    (resp_bit),
    .apply       (apply),
    .en_eff      (en_eff),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .idx_q       (idx_q),
    .work_slice  (work_slice),
    .chain_data  (chain_data),
    .chain_valid (chain_valid)
);

// File: tb/slice_mutator_test.sv
module slice_mutator_test;
    localparam int W  = 8;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic share_mode = 1'b0;
    logic ser_idx = 1'b0;
    logic flip_req = 1'b0;
    logic pad_in = 1'b0;
    logic resp_bit = 1'b0;
    logic apply = 1'b0;
    logic pad_out, pad_oe, chain_valid;
    logic [W-1:0] work_slice, chain_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [IW-1:0] m_idx;
    logic [W-1:0]  m_slice, m_cd;
    logic          m_cv;

    always #4 clk = ~clk;

    slice_mutator #(.SLICE_W(W)) uut (
        .clk(clk), .rst(rst), .share_mode(share_mode), .ser_idx(ser_idx),
        .flip_req(flip_req), .pad_in(pad_in), .resp_bit(resp_bit), .apply(apply),
        .pad_out(pad_out), .pad_oe(pad_oe), .work_slice(work_slice),
        .chain_data(chain_data), .chain_valid(chain_valid)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_model(input string req);
        check(req, "work_slice", 32'(work_slice), 32'(m_slice));
        check(req, "chain_valid", 32'(chain_valid), 32'(m_cv));
        check(req, "chain_data", 32'(chain_data), 32'(m_cd));
    endtask

    // one clock: drive at the falling edge, sample 1 ns after the rising edge
    task automatic step(input logic b, input logic e, input logic a, input string req);
        logic [IW-1:0] nidx;
        logic eff;
        ser_idx = b; flip_req = e; apply = a;
        eff  = share_mode ? pad_in : e;
        nidx = {b, m_idx[IW-1:1]};
        @(posedge clk); #1;
        m_cv = a;
        if (a) m_cd = m_slice;
        if (eff) m_slice[nidx] = ~m_slice[nidx];
        m_idx = nidx;
        check_model(req);
        @(negedge clk);
        ser_idx = 1'b0; flip_req = 1'b0; apply = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        m_idx = '0; m_slice = '0; m_cd = '0; m_cv = 1'b0;
        check("R1", "work_slice", 32'(work_slice), 32'h0);
        check("R1", "chain_valid", 32'(chain_valid), 32'h0);
        check("R1", "chain_data", 32'(chain_data), 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_single_flip();
        step(1'b1, 1'b0, 1'b0, "R4");
        step(1'b0, 1'b0, 1'b0, "R4");
        step(1'b1, 1'b1, 1'b0, "R2");
        check("R2", "index 101 selects bit 5", 32'(work_slice), 32'h20);
    endtask

    task automatic t_overlap();
        step(1'b1, 1'b1, 1'b0, "R5");
        check("R5", "index 110 flips bit 6", 32'(work_slice), 32'h60);
        step(1'b1, 1'b1, 1'b0, "R5");
        check("R5", "index 111 flips bit 7", 32'(work_slice), 32'hE0);
    endtask

    task automatic t_no_enable();
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, "R4");
        check("R4", "slice kept without enable", 32'(work_slice), 32'hE0);
    endtask

    task automatic t_toggle_back();
        step(1'b0, 1'b1, 1'b0, "R3");
        check("R3", "index 0 flips bit 0", 32'(work_slice), 32'hE1);
        step(1'b0, 1'b1, 1'b0, "R3");
        check("R3", "second flip restores bit 0", 32'(work_slice), 32'hE0);
    endtask

    task automatic t_apply();
        step(1'b0, 1'b0, 1'b1, "R6");
        check("R6", "chain_valid after apply", 32'(chain_valid), 32'h1);
        check("R6", "chain_data after apply", 32'(chain_data), 32'hE0);
        check("R6", "slice kept by apply", 32'(work_slice), 32'hE0);
        step(1'b0, 1'b0, 1'b0, "R7");
        check("R7", "valid is a single pulse", 32'(chain_valid), 32'h0);
        check("R7", "chain_data held", 32'(chain_data), 32'hE0);
    endtask

    task automatic t_apply_with_flip();
        step(1'b1, 1'b1, 1'b1, "R6");
        check("R6", "emitted slice excludes same-clock flip", 32'(chain_data), 32'hE0);
        check("R6", "same-clock flip kept in slice", 32'(work_slice), 32'hF0);
    endtask

    task automatic t_share();
        resp_bit = 1'b1; #1;
        check("R8", "pad_oe dedicated", 32'(pad_oe), 32'h1);
        check("R8", "pad_out follows response", 32'(pad_out), 32'h1);
        share_mode = 1'b1; pad_in = 1'b0; #1;
        check("R8", "pad_oe shared", 32'(pad_oe), 32'h0);
        check("R8", "pad_out shared", 32'(pad_out), 32'h0);
        step(1'b0, 1'b1, 1'b0, "R8");
        check("R8", "dedicated enable ignored in shared mode", 32'(work_slice), 32'hF0);
        pad_in = 1'b1;
        step(1'b0, 1'b0, 1'b0, "R8");
        check("R8", "pad enable flips bit 1", 32'(work_slice), 32'hF2);
        pad_in = 1'b0; share_mode = 1'b0; resp_bit = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single_flip();
        t_overlap();
        t_no_enable();
        t_toggle_back();
        t_apply();
        t_apply_with_flip();
        t_share();
        repeat (2) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule